// File: doc/BRIEF.md
# Dual-Rate Frame Sync Generator

This block derives two frame-timing outputs from one output-clock domain. The fast output marks every 125 µs frame (8 kHz). The slow output marks every group of four frames, i.e. 500 µs (2 kHz). Either output can be a 50 % square clock or a one-clock-wide active-low frame pulse, and either can be inverted. Each output can be switched off, which forces it low.

The output clock rate is given as `div_n`, the number of output-clock cycles in one 125 µs frame. A phase counter and a two-bit frame counter form one counter chain, so the slow output stays phase-locked to the fast one. Settings are taken into shadow registers only at period boundaries, so a change made while running never produces a runt pulse. Both outputs come straight from flops.

Top module: `frame_sync_gen`

## Requirements
- R1: An output whose enable is 0 (as last sampled at its boundary) is driven 0, whatever its mode and invert bits.
- R2: Fast output, square mode, not inverted: each frame of N cycles is high for floor(N/2) cycles, then low for the remaining cycles, and starts high.
- R3: Fast output, pulse mode, not inverted: low for exactly the first cycle of each frame and high for every other cycle.
- R4: Fast invert bit = 1 inverts the fast waveform in both modes (pulse mode then gives a one-cycle high pulse).
- R5: Slow output, square mode, not inverted: high for frames 0 and 1 and low for frames 2 and 3 of each group of four frames, so its edges coincide with fast-output frame starts.
- R6: Slow output, pulse mode, not inverted: low for one cycle, the first cycle of frame 0, which is the same cycle as every fourth fast-output frame start.
- R7: Slow invert bit = 1 inverts the slow waveform in both modes.
- R8: A frame lasts N = `div_n` output-clock cycles for any N from 2 up to 2^CNT_W−1 (193 and above included); a value of 0 or 1 is treated as 2.
- R9: `div_n` and the fast output's enable, mode and invert bits are sampled only in the last cycle of a frame; the slow output's bits only in the last cycle of frame 3. A change elsewhere alters nothing until then.
- R10: While `rst_n` is 0 (sampled at a rising edge), both outputs are 0 and all settings are loaded from the inputs; the first edge with `rst_n` = 1 begins frame 0 at position 0, and each output shows its frame-0 position-0 level after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_n | input | CNT_W | Output-clock cycles per 125 µs frame |
| fs_en | input | 1 | Fast output enable |
| fs_pulse | input | 1 | Fast output: 1 = one-cycle pulse, 0 = square |
| fs_inv | input | 1 | Fast output polarity invert |
| mfs_en | input | 1 | Slow output enable |
| mfs_pulse | input | 1 | Slow output: 1 = one-cycle pulse, 0 = square |
| mfs_inv | input | 1 | Slow output polarity invert |
| fs_out | output | 1 | 8 kHz frame output |
| mfs_out | output | 1 | 2 kHz frame output |

## Verification
A wrong phase count moves the fast output's pulse or square edge within one frame, so it shows at the ports no later than N cycles after the fault. A wrong frame count moves the slow output against every fourth fast marker and is visible within four frames. A shadow register loaded at the wrong time shows a mode, polarity or period change before the boundary, often as a runt pulse on the very next cycle, which the cycle-by-cycle reference catches at once.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // Frames in one slow-output period
  localparam int unsigned FRAMES_PER_GROUP = 4;

  typedef struct packed {
    logic en;
    logic pulse;
    logic inv;
  } shape_cfg_t;

  // Effective frame length: below two cycles is raised to two
  function automatic int unsigned eff_len(input int unsigned n);
    return (n < 2) ? 2 : n;
  endfunction

  // Cycles in the high phase of a square frame
  function automatic int unsigned high_len(input int unsigned n);
    return eff_len(n) / 2;
  endfunction

  // Level of one output given its marker, square phase and settings
  function automatic logic shape_level(input logic mark, input logic high,
                                       input shape_cfg_t c);
    logic raw;
    raw = c.pulse ? ~mark : high;
    return c.en ? (raw ^ c.inv) : 1'b0;
  endfunction

endpackage

// File: rtl/fsg_timebase.sv
module fsg_timebase
  import fsg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FR_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_n,
  output logic             frame_mark,
  output logic             frame_high,
  output logic             group_mark,
  output logic             group_high,
  output logic             frame_tick,
  output logic             group_tick
);

  localparam logic [FR_W-1:0] FR_LAST = {FR_W{1'b1}};

  logic [CNT_W-1:0] ph_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] half_w;
  logic [FR_W-1:0]  fr_q;
  logic [CNT_W-1:0] len_in_w;

  assign len_in_w   = CNT_W'(eff_len(32'(div_n)));
  assign half_w     = CNT_W'(high_len(32'(len_q)));
  assign frame_tick = (ph_q == len_q - 1'b1);
  assign group_tick = frame_tick && (fr_q == FR_LAST);
  assign frame_mark = (ph_q == '0);
  assign group_mark = frame_mark && (fr_q == '0);
  assign frame_high = (ph_q < half_w);
  assign group_high = ~fr_q[FR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      fr_q  <= '0;
      len_q <= len_in_w;
    end else if (frame_tick) begin
      ph_q  <= '0;
      fr_q  <= fr_q + 1'b1;
      len_q <= len_in_w;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  // R8: the phase never reaches the frame length
  a_r8_phase_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < len_q);

  // R8: the frame always restarts at position zero after its last cycle
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (ph_q == '0));

  // R5: the frame count moves only across a frame boundary
  a_r5_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(fr_q));

endmodule

// File: rtl/fsg_shaper.sv
module fsg_shaper
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  shape_cfg_t cfg_i,
  input  logic       mark_i,
  input  logic       high_i,
  output shape_cfg_t cfg_o,
  output logic       wave_o
);

  shape_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= cfg_i;
      wave_o <= 1'b0;
    end else begin
      if (load) cfg_q <= cfg_i;
      wave_o <= shape_level(mark_i, high_i, cfg_q);
    end
  end

  assign cfg_o = cfg_q;

  // R1: a disabled output is low on the following cycle
  a_r1_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |=> !wave_o);

  // R3: an active-low pulse lasts a single cycle
  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_q.en && cfg_q.pulse && !cfg_q.inv) && $fell(wave_o)) |=> wave_o);

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_n,
  input  logic             fs_en,
  input  logic             fs_pulse,
  input  logic             fs_inv,
  input  logic             mfs_en,
  input  logic             mfs_pulse,
  input  logic             mfs_inv,
  output logic             fs_out,
  output logic             mfs_out
);

  localparam int FR_W  = $clog2(FRAMES_PER_GROUP);
  localparam int N_OUT = 2;

  logic       frame_mark, frame_high, group_mark, group_high;
  logic       frame_tick, group_tick;
  shape_cfg_t cfg_in  [N_OUT];
  shape_cfg_t cfg_sh  [N_OUT];
  logic       mark_v  [N_OUT];
  logic       high_v  [N_OUT];
  logic       load_v  [N_OUT];
  logic       wave_v  [N_OUT];

  fsg_timebase #(.CNT_W(CNT_W), .FR_W(FR_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_n      (div_n),
    .frame_mark (frame_mark),
    .frame_high (frame_high),
    .group_mark (group_mark),
    .group_high (group_high),
    .frame_tick (frame_tick),
    .group_tick (group_tick)
  );

  assign cfg_in[0] = '{en: fs_en,  pulse: fs_pulse,  inv: fs_inv};
  assign cfg_in[1] = '{en: mfs_en, pulse: mfs_pulse, inv: mfs_inv};
  assign mark_v[0] = frame_mark;
  assign mark_v[1] = group_mark;
  assign high_v[0] = frame_high;
  assign high_v[1] = group_high;
  assign load_v[0] = frame_tick;
  assign load_v[1] = group_tick;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    fsg_shaper u_shp (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_v[i]),
      .cfg_i  (cfg_in[i]),
      .mark_i (mark_v[i]),
      .high_i (high_v[i]),
      .cfg_o  (cfg_sh[i]),
      .wave_o (wave_v[i])
    );
  end

  assign fs_out  = wave_v[0];
  assign mfs_out = wave_v[1];

  logic both_plain_pulse;
  assign both_plain_pulse = cfg_sh[0].en && cfg_sh[0].pulse && !cfg_sh[0].inv &&
                            cfg_sh[1].en && cfg_sh[1].pulse && !cfg_sh[1].inv;

  // R6: a slow pulse always lands on a fast pulse
  a_r6_pulse_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(both_plain_pulse) && !mfs_out) |-> !fs_out);

  // R10: outputs are low during reset
  a_r10_reset_low: assert property (@(posedge clk)
    $past(!rst_n) |-> (!fs_out && !mfs_out));

endmodule

// File: tb/frame_sync_gen_test.sv
module frame_sync_gen_test;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] div_n = 16'd10;
  logic fs_en = 1'b1, fs_pulse = 1'b0, fs_inv = 1'b0;
  logic mfs_en = 1'b1, mfs_pulse = 1'b0, mfs_inv = 1'b0;
  logic fs_out, mfs_out;

  int checks = 0;
  int fails  = 0;
  string scen = "R10 reset";

  frame_sync_gen #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .div_n(div_n),
    .fs_en(fs_en), .fs_pulse(fs_pulse), .fs_inv(fs_inv),
    .mfs_en(mfs_en), .mfs_pulse(mfs_pulse), .mfs_inv(mfs_inv),
    .fs_out(fs_out), .mfs_out(mfs_out)
  );

  always #5 clk = ~clk;

  // Behavioural reference: position, frame and latched settings
  int pos, frm, nlen;
  bit fe, fp, fi, me, mp, mi;
  bit efs, emfs;
  string ftag = "R10", mtag = "R10";

  function automatic int clampn(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; frm = 0; nlen = clampn(int'(div_n));
      fe = fs_en; fp = fs_pulse; fi = fs_inv;
      me = mfs_en; mp = mfs_pulse; mi = mfs_inv;
      efs = 0; emfs = 0; ftag = "R10"; mtag = "R10";
    end else begin
      efs  = fe ? ((fp ? (pos != 0) : (pos < nlen / 2)) ^ fi) : 1'b0;
      emfs = me ? ((mp ? !(pos == 0 && frm == 0) : (frm < 2)) ^ mi) : 1'b0;
      ftag = !fe ? "R1" : fi ? "R4" : fp ? "R3" : "R2";
      mtag = !me ? "R1" : mi ? "R7" : mp ? "R6" : "R5";
      if (pos == nlen - 1) begin
        pos = 0; frm = (frm + 1) % 4; nlen = clampn(int'(div_n));
        fe = fs_en; fp = fs_pulse; fi = fs_inv;
        if (frm == 0) begin me = mfs_en; mp = mfs_pulse; mi = mfs_inv; end
      end else begin
        pos = pos + 1;
      end
    end
  end

  task automatic check(input string req, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] at %0t: actual %b expected %b", req, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(ftag, fs_out, efs);
    check(mtag, mfs_out, emfs);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tests();
    // R10: held in reset, both outputs low
    run(4);
    rst_n = 1'b1;
    scen = "R2 R5 even N";
    run(120);
    scen = "R2 odd N, R9 mid-frame change";
    div_n = 16'd9;
    run(3);
    fs_pulse = 1'b1;       // R9: must wait for the frame end
    run(80);
    scen = "R3 R6 pulses";
    mfs_pulse = 1'b1;
    run(120);
    scen = "R4 R7 inverted";
    fs_inv = 1'b1; mfs_inv = 1'b1;
    run(90);
    fs_pulse = 1'b0; mfs_pulse = 1'b0;
    run(90);
    scen = "R1 disabled";
    fs_en = 1'b0; mfs_en = 1'b0;
    run(90);
    fs_en = 1'b1; mfs_en = 1'b1; fs_inv = 1'b0; mfs_inv = 1'b0;
    scen = "R8 clamp N=1";
    div_n = 16'd1;
    run(40);
    div_n = 16'd0;
    run(40);
    scen = "R8 N=193 pulses";
    div_n = 16'd193; fs_pulse = 1'b1; mfs_pulse = 1'b1;
    run(1700);
    scen = "R10 reset again";
    rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
    run(50);
  endtask

  initial begin
    fork
      tests();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule